// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer

This block drives an electrically programmable ROM through a byte-by-byte programming run. A single `start` pulse makes it walk every address from zero upward. At each address it raises the programming-level flag, presents the address and the wanted byte, and holds them steady for a setup window. It then lowers chip enable for one timed program pulse and keeps address and data for a hold window. After that it drops the programming level and reads the byte back with chip enable and output enable both low. If the byte read back differs from the source image, the same address is pulsed again. The number of pulses per byte is capped.

Once every byte has verified, the sequencer makes a second pass over the whole array in plain read mode and compares each byte with the source image. It finishes with `done` high and `pass` giving the result. On a failure `failAddr` keeps the address where the run stopped. The wanted bytes come from a source-image read port, which is indexed by the same address the ROM sees. All durations are parameters counted in clock cycles. Generating the actual voltages is left to the surrounding logic.

Top module: `byte_prog_seq`

## Requirements
- R1: While reset is asserted and after it is released, `done` and `pass` are 0, `ceN` and `oeN` are 1, `vppHigh` is 0 and `failAddr` is 0.
- R2: Every program pulse keeps `ceN` low for exactly PULSE_CYC cycles. During the pulse `vppHigh` is 1 and `oeN` is 1.
- R3: Before `ceN` falls for a pulse, `romAddr` and `romWrData` have been unchanged for at least SETUP_CYC cycles with `ceN` high. After `ceN` rises, they stay unchanged for at least HOLD_CYC cycles.
- R4: Each read-back, whether a verify or a final-compare read, keeps `vppHigh` 0 and `oeN` and `ceN` low for exactly VERIFY_CYC cycles on one address. Chip enable does not toggle during a read.
- R5: A verify read that differs from `srcData` leads to another program pulse on the same address.
- R6: If a byte still differs after MAX_PULSES pulses (default 25), the run ends with `done`=1 and `pass`=0, and `failAddr` holds that address. No later address is pulsed.
- R7: A verify read that matches moves to the next address, and the pulse budget starts again for that byte. Addresses are programmed in ascending order starting at 0.
- R8: After the last address (all ones) verifies, every byte is read again in ascending order and compared with `srcData`. The first mismatch ends the run with `pass`=0 and `failAddr` holding that address.
- R9: When the final compare finds no mismatch, the run ends with `done`=1 and `pass`=1.
- R10: `start` is ignored while a run is in progress. `start` while idle or done begins a new run from address 0.
- R11: `done` and `pass` hold until the next `start`. While done, `ceN`=1, `oeN`=1 and `vppHigh`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a programming run |
| done | output | 1 | Run finished |
| pass | output | 1 | Run result, valid with done |
| failAddr | output | ADDR_W | Address where a failed run stopped |
| srcAddr | output | ADDR_W | Index into the source image |
| srcData | input | DATA_W | Wanted byte at srcAddr |
| ceN | output | 1 | ROM chip enable, active low |
| oeN | output | 1 | ROM output enable, active low |
| vppHigh | output | 1 | Output-enable pin at programming level |
| romAddr | output | ADDR_W | ROM address |
| romWrData | output | DATA_W | Byte driven onto the ROM data pins |
| romRdData | input | DATA_W | Byte read back from the ROM |

## Verification
The checker assumes a few things about the inputs. `srcData` is a pure function of `srcAddr` that does not change during a run. `romRdData` is settled by the last cycle of each read window. Reset is asserted from time zero. The bench keeps to these assumptions in several ways. Its source image is a fixed array that is only rewritten between runs. Its ROM model answers reads combinationally and applies a program pulse only when chip enable rises at programming level. All stimulus changes on the falling clock edge. Random images and per-byte pulse needs are mixed with directed cases: a byte that needs exactly the cap, one that needs one pulse more, a cell that cannot reach its value, and a late pulse that disturbs bytes already verified.

// File: rtl/pgmseq_pkg.sv
package pgmseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_VERIFY, ST_CMP, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic tmrClr;
    logic addrClr;
    logic addrInc;
    logic tryClr;
    logic tryInc;
    logic failLatch;
  } seqStrobe_t;

endpackage

// File: rtl/pgmseq_datapath.sv
module pgmseq_datapath
  import pgmseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TMR_W  = 16,
  parameter int TRY_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] romRdData,
  output logic [ADDR_W-1:0] addr,
  output logic [TMR_W-1:0]  tmr,
  output logic [TRY_W-1:0]  tryCnt,
  output logic [ADDR_W-1:0] failAddr,
  output logic              lastAddr,
  output logic              dataEq
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr     <= '0;
      tmr      <= '0;
      tryCnt   <= '0;
      failAddr <= '0;
    end else begin
      if (stb.tmrClr)        tmr <= '0;
      else if (tmr != '1)    tmr <= tmr + 1'b1;

      if (stb.addrClr)       addr <= '0;
      else if (stb.addrInc)  addr <= addr + 1'b1;

      if (stb.tryClr)        tryCnt <= '0;
      else if (stb.tryInc)   tryCnt <= tryCnt + 1'b1;

      if (stb.failLatch)     failAddr <= addr;
    end
  end

  assign lastAddr = &addr;
  assign dataEq   = (romRdData == srcData);

endmodule

// File: rtl/pgmseq_ctrl.sv
module pgmseq_ctrl
  import pgmseq_pkg::*;
#(
  parameter int TMR_W      = 16,
  parameter int TRY_W      = 5,
  parameter int SETUP_CYC  = 3,
  parameter int PULSE_CYC  = 25000,
  parameter int HOLD_CYC   = 3,
  parameter int VERIFY_CYC = 4,
  parameter int MAX_PULSES = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [TMR_W-1:0] tmr,
  input  logic [TRY_W-1:0] tryCnt,
  input  logic             lastAddr,
  input  logic             dataEq,
  output seqStrobe_t       stb,
  output logic             done,
  output logic             pass,
  output logic             ceN,
  output logic             oeN,
  output logic             vppHigh
);

  localparam logic [TMR_W-1:0] SETUP_END  = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] PULSE_END  = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] HOLD_END   = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] VERIFY_END = TMR_W'(VERIFY_CYC - 1);
  localparam logic [TRY_W-1:0] LAST_TRY   = TRY_W'(MAX_PULSES - 1);

  seqState_t state, stateNxt;
  logic      passReg, passNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      passReg <= 1'b0;
    end else begin
      state   <= stateNxt;
      passReg <= passNxt;
    end
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    passNxt  = passReg;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          stb.addrClr = 1'b1;
          stb.tryClr  = 1'b1;
          stb.tmrClr  = 1'b1;
          passNxt     = 1'b0;
          stateNxt    = ST_SETUP;
        end
      end
      ST_SETUP: if (tmr == SETUP_END) begin
        stb.tmrClr = 1'b1;
        stateNxt   = ST_PULSE;
      end
      ST_PULSE: if (tmr == PULSE_END) begin
        stb.tmrClr = 1'b1;
        stateNxt   = ST_HOLD;
      end
      ST_HOLD: if (tmr == HOLD_END) begin
        stb.tmrClr = 1'b1;
        stateNxt   = ST_VERIFY;
      end
      ST_VERIFY: if (tmr == VERIFY_END) begin
        stb.tmrClr = 1'b1;
        if (dataEq) begin
          if (lastAddr) begin
            stb.addrClr = 1'b1;
            stateNxt    = ST_CMP;
          end else begin
            stb.addrInc = 1'b1;
            stb.tryClr  = 1'b1;
            stateNxt    = ST_SETUP;
          end
        end else if (tryCnt == LAST_TRY) begin
          stb.failLatch = 1'b1;
          stateNxt      = ST_DONE;
        end else begin
          stb.tryInc = 1'b1;
          stateNxt   = ST_SETUP;
        end
      end
      ST_CMP: if (tmr == VERIFY_END) begin
        stb.tmrClr = 1'b1;
        if (!dataEq) begin
          stb.failLatch = 1'b1;
          stateNxt      = ST_DONE;
        end else if (lastAddr) begin
          passNxt  = 1'b1;
          stateNxt = ST_DONE;
        end else begin
          stb.addrInc = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign done    = (state == ST_DONE);
  assign pass    = passReg;
  assign ceN     = !(state == ST_PULSE || state == ST_VERIFY || state == ST_CMP);
  assign oeN     = !(state == ST_VERIFY || state == ST_CMP);
  assign vppHigh = (state == ST_SETUP || state == ST_PULSE || state == ST_HOLD);

endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
  import pgmseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 3,
  parameter int PULSE_CYC  = 25000,
  parameter int HOLD_CYC   = 3,
  parameter int VERIFY_CYC = 4,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] failAddr,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [DATA_W-1:0] srcData,
  output logic              ceN,
  output logic              oeN,
  output logic              vppHigh,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romWrData,
  input  logic [DATA_W-1:0] romRdData
);

  localparam int MAX_A   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_B   = (PULSE_CYC > VERIFY_CYC) ? PULSE_CYC : VERIFY_CYC;
  localparam int TMR_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int TRY_W   = $clog2(MAX_PULSES + 1);

  seqStrobe_t        stb;
  logic [ADDR_W-1:0] addr;
  logic [TMR_W-1:0]  tmr;
  logic [TRY_W-1:0]  tryCnt;
  logic              lastAddr;
  logic              dataEq;

  pgmseq_ctrl #(
    .TMR_W(TMR_W), .TRY_W(TRY_W), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .VERIFY_CYC(VERIFY_CYC), .MAX_PULSES(MAX_PULSES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .tmr(tmr), .tryCnt(tryCnt),
    .lastAddr(lastAddr), .dataEq(dataEq), .stb(stb), .done(done), .pass(pass),
    .ceN(ceN), .oeN(oeN), .vppHigh(vppHigh)
  );

  pgmseq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMR_W(TMR_W), .TRY_W(TRY_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .srcData(srcData), .romRdData(romRdData),
    .addr(addr), .tmr(tmr), .tryCnt(tryCnt), .failAddr(failAddr),
    .lastAddr(lastAddr), .dataEq(dataEq)
  );

  assign srcAddr   = addr;
  assign romAddr   = addr;
  assign romWrData = srcData;

endmodule

// File: rtl/byte_prog_seq_chk.sv
module byte_prog_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              pass,
  input logic              ceN,
  input logic              oeN,
  input logic              vppHigh,
  input logic [ADDR_W-1:0] romAddr
);

  // R2
  pulse_oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && vppHigh) |-> oeN);

  // R2
  vpp_steady_low_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !$past(ceN)) |-> $stable(vppHigh));

  // R3
  addr_steady_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && vppHigh && !$past(ceN)) |-> $stable(romAddr));

  // R4
  verify_no_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!ceN && !vppHigh) && ceN) |-> (vppHigh || done));

  // R9
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done);

  // R11
  done_idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ceN && oeN && !vppHigh));

  // R11
  done_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

endmodule

bind byte_prog_seq byte_prog_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .pass(pass),
  .ceN(ceN), .oeN(oeN), .vppHigh(vppHigh), .romAddr(romAddr)
);

// File: tb/byte_prog_seq_tb.sv
module byte_prog_seq_tb;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N = 1 << AW;
  localparam int SETUP_CYC = 2;
  localparam int PULSE_CYC = 5;
  localparam int HOLD_CYC = 2;
  localparam int VERIFY_CYC = 3;
  localparam int MAXP = 25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic done, pass, ceN, oeN, vppHigh;
  logic [AW-1:0] failAddr, srcAddr, romAddr;
  logic [DW-1:0] srcData, romWrData, romRdData;

  logic [DW-1:0] img [N];
  logic [DW-1:0] mem [N];
  logic [DW-1:0] mem0 [N];
  int need [N];
  int pulseCnt [N];
  int expPulse [N];
  bit disturbOn;
  int victimA, victimB, trigAddr;
  bit expPass;
  int expFail;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  byte_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .VERIFY_CYC(VERIFY_CYC), .MAX_PULSES(MAXP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .pass(pass),
    .failAddr(failAddr), .srcAddr(srcAddr), .srcData(srcData), .ceN(ceN),
    .oeN(oeN), .vppHigh(vppHigh), .romAddr(romAddr), .romWrData(romWrData),
    .romRdData(romRdData)
  );

  assign srcData   = img[srcAddr];
  assign romRdData = (!ceN && !oeN && !vppHigh) ? mem[romAddr] : '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      finishRun();
    end
  end

  // ROM model and pin-timing monitor
  logic prevCeN = 1'b1, prevVpp = 1'b0, prevRd = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  logic [DW-1:0] prevWr = '0;
  int lowLen = 0, stableCnt = 0, sinceRise = 0, runLen = 0;
  bit anyPulse = 1'b0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevCeN = 1'b1; prevVpp = 1'b0; prevRd = 1'b0;
      lowLen = 0; stableCnt = 0; sinceRise = 0; runLen = 0; anyPulse = 1'b0;
    end else begin
      logic rd;
      bit moved;
      rd = !ceN && !oeN && !vppHigh;
      moved = (romAddr != prevAddr) || (romWrData != prevWr);
      sinceRise++;
      if (!ceN && vppHigh) begin
        lowLen++;
        if (!oeN) chk(1'b0, "R2", "oeN low during pulse", oeN, 1);
        if (prevCeN) chk(stableCnt >= SETUP_CYC, "R3", "setup cycles", stableCnt, SETUP_CYC);
      end
      if (!prevCeN && prevVpp && ceN) begin
        chk(lowLen == PULSE_CYC, "R2", "pulse width", lowLen, PULSE_CYC);
        lowLen = 0;
        sinceRise = 0;
        anyPulse = 1'b1;
        pulseCnt[romAddr]++;
        if (pulseCnt[romAddr] >= need[romAddr]) mem[romAddr] = mem[romAddr] & romWrData;
        if (disturbOn && int'(romAddr) == trigAddr) begin
          mem[victimA] = mem[victimA] & 8'hFE;
          mem[victimB] = mem[victimB] & 8'hFE;
        end
      end
      if (moved) begin
        if (anyPulse) chk(sinceRise >= HOLD_CYC, "R3", "hold cycles", sinceRise, HOLD_CYC);
        stableCnt = (ceN) ? 1 : 0;
      end else if (ceN) begin
        stableCnt++;
      end
      if (prevRd && !(rd && romAddr == prevAddr))
        chk(runLen == VERIFY_CYC, "R4", "read window", runLen, VERIFY_CYC);
      if (rd) runLen = (prevRd && romAddr == prevAddr) ? runLen + 1 : 1;
      else runLen = 0;
      prevCeN = ceN; prevVpp = vppHigh; prevRd = rd;
      prevAddr = romAddr; prevWr = romWrData;
    end
  end

  task automatic prep();
    for (int a = 0; a < N; a++) begin
      img[a] = DW'($urandom);
      mem[a] = '1;
      need[a] = 1 + int'($urandom % 4);
      pulseCnt[a] = 0;
    end
    disturbOn = 1'b0;
  endtask

  function automatic void computeExp();
    bit failed = 1'b0;
    expPass = 1'b1;
    expFail = 0;
    for (int a = 0; a < N; a++) begin
      mem0[a] = mem[a];
      if (failed) expPulse[a] = 0;
      else if (need[a] > MAXP || ((mem[a] & img[a]) != img[a])) begin
        expPulse[a] = MAXP; failed = 1'b1; expPass = 1'b0; expFail = a;
      end else expPulse[a] = need[a];
    end
    if (!failed && disturbOn) begin
      expPass = 1'b0;
      expFail = (victimA < victimB) ? victimA : victimB;
    end
  endfunction

  task automatic runCheck(input string tag, input bit midStart);
    int cnt = 0;
    computeExp();
    for (int a = 0; a < N; a++) pulseCnt[a] = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(done == 1'b0, "R10", {tag, " done drops after start"}, done, 0);
    while (!done && cnt < 20000) begin
      start = (midStart && (cnt == 40 || cnt == 41)) ? 1'b1 : 1'b0;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    if (!done) begin
      chk(1'b0, "R9", {tag, " run never finished"}, cnt, 20000);
      finishRun();
    end
    if (expPass) chk(pass == 1'b1, "R9", {tag, " pass"}, pass, 1);
    else begin
      chk(pass == 1'b0, "R6 R8", {tag, " pass"}, pass, 0);
      chk(failAddr == AW'(expFail), "R6 R8", {tag, " failAddr"}, failAddr, expFail);
    end
    for (int a = 0; a < N; a++)
      chk(pulseCnt[a] == expPulse[a], "R5 R6 R7", {tag, " pulses per address"},
          pulseCnt[a], expPulse[a]);
  endtask

  initial begin
    void'($urandom(32'd4242));
    prep();
    repeat (3) @(negedge clk);
    chk(done == 0 && pass == 0, "R1", "done/pass in reset", {done, pass}, 0);
    chk(ceN == 1 && oeN == 1 && vppHigh == 0, "R1", "pins in reset", {ceN, oeN, vppHigh}, 3'b110);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 0 && ceN == 1 && oeN == 1 && vppHigh == 0, "R1", "idle after reset",
        {done, ceN, oeN, vppHigh}, 4'b0110);
    chk(failAddr == 0, "R1", "failAddr after reset", failAddr, 0);

    // random images, several pulse needs
    for (int i = 0; i < 3; i++) begin
      prep();
      runCheck("random", 1'b0);
    end

    // boundary: exactly the cap succeeds (R6 edge)
    prep();
    need[3] = MAXP;
    runCheck("cap exact R6", 1'b0);

    // one beyond the cap fails, later addresses untouched
    prep();
    need[5] = MAXP + 1;
    runCheck("cap exceeded R6", 1'b0);

    // cell that cannot reach its value
    prep();
    img[9] = 8'h5A;
    mem[9] = 8'h00;
    runCheck("stuck cell R6", 1'b0);

    // disturb of verified bytes caught by the final ascending compare
    prep();
    victimA = 6; victimB = 2; trigAddr = 11;
    img[2] = img[2] | 8'h01;
    img[6] = img[6] | 8'h01;
    disturbOn = 1'b1;
    runCheck("final compare R8", 1'b0);

    // start while busy is ignored
    prep();
    runCheck("busy start R10", 1'b1);

    // done and pins hold without start
    repeat (10) @(negedge clk);
    chk(done == 1 && pass == 1, "R11", "done held", {done, pass}, 2'b11);
    chk(ceN == 1 && oeN == 1 && vppHigh == 0, "R11", "pins idle in done",
        {ceN, oeN, vppHigh}, 3'b110);

    // restart from done after a failing run clears pass and succeeds again
    prep();
    need[0] = MAXP + 1;
    runCheck("fail at zero R6", 1'b0);
    prep();
    runCheck("restart R10", 1'b0);

    finishRun();
  end

endmodule